// File: doc/BRIEF.md
# Vector Carry-Less Multiply-Long Unit

This SIMD execution unit multiplies lanes of two 128-bit source registers as polynomials over GF(2). Partial products are combined with XOR, so no carries ever occur, and every product is twice as wide as the lanes that form it. A half-select bit in the instruction picks the 64-bit operand from either the low or the high half of both sources. A two-bit size field picks the lane layout: eight 8-bit lanes with 16-bit products, or a single 64-bit lane with a 128-bit product. The wide form needs a feature-enable input.

The issue stage presents an instruction word with a valid strobe, and the two source register values beside it. Two cycles later the unit returns either a 128-bit result with a valid strobe and the destination register index, or an undefined-instruction strobe, which means nothing may be written. A new instruction can be accepted in every cycle. The unit has no condition flags.

Top module: `clmul_long_unit`

## Requirements
- R1: Every lane product is the carry-less product: result bit k of a lane is the XOR over all i+j=k of a[i] AND b[j], with no carry into higher bits.
- R2: When instruction bit 30 (half-select) is 0, both operands come from bits [63:0] of their source registers.
- R3: When instruction bit 30 is 1, both operands come from bits [127:64] of their source registers.
- R4: Size field bits [23:22] = 00 gives eight 8-bit lanes. Lane e multiplies operand bits [8e+7:8e] and places its 16-bit product at result bits [16e+15:16e]. Bit 15 of every lane product is always 0.
- R5: Size field 11 with `wide_en` high gives one 64-bit lane whose 128-bit product fills the whole result. Result bit 127 is always 0.
- R6: Size field 01 or 10, or 11 with `wide_en` low, raises `out_undef` with `out_valid` low in the result slot of that instruction.
- R7: Results appear exactly two cycles after the accepting edge. One instruction can be issued per cycle. A cycle with `in_valid` low produces neither `out_valid` nor `out_undef` two cycles later.
- R8: `out_dst` equals instruction bits [4:0] of the instruction whose `out_valid` or `out_undef` is showing.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `out_undef` are low after that edge, and `in_valid` during reset creates no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_en | input | 1 | Enables the 64-bit-lane form |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Instruction word |
| src_a | input | 128 | First source register value |
| src_b | input | 128 | Second source register value |
| out_valid | output | 1 | Result valid; the destination may be written |
| out_undef | output | 1 | Undefined instruction; the destination must not be written |
| out_dst | output | 5 | Destination register index |
| out_result | output | 128 | Widened product vector |

## Verification
The two functions that can land in the same cycle are the undefined-instruction path and the valid-result path. The first instruction is being retired while the second is being decoded, and the pipeline holds both. The bench provokes this by issuing legal and illegal encodings back to back, including wide-form instructions with `wide_en` toggling between adjacent cycles. Each output slot is judged on its own against a bench-side pipeline of expected values: the valid strobe, the undefined strobe, the destination and the product must all belong to the instruction issued exactly two cycles earlier.

// File: rtl/clmul_pkg.sv
// Package: shared types and instruction field positions for the
// carry-less multiply-long unit. Assumes a 32-bit instruction word.
package clmul_pkg;

    // Lane layout chosen by the size field
    typedef enum logic [0:0] {
        LANE_NARROW = 1'b0,
        LANE_WIDE   = 1'b1
    } lane_mode_e;

    localparam int unsigned POS_HALF    = 30;
    localparam int unsigned POS_SIZE_LO = 22;
    localparam int unsigned SIZE_W      = 2;
    localparam int unsigned DST_W       = 5;

    localparam logic [SIZE_W-1:0] SIZE_NARROW = 2'b00;
    localparam logic [SIZE_W-1:0] SIZE_WIDE   = 2'b11;

endpackage

// File: rtl/clmul_decode.sv
// Module: clmul_decode
// Pulls the half-select, size and destination fields out of the
// instruction word and judges whether the encoding is legal.
// Assumes the opcode bits were matched upstream; register source
// fields are not used because operands arrive as values.
module clmul_decode
    import clmul_pkg::*;
#(
    parameter int unsigned INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               wide_en,
    output logic               half_hi,
    output lane_mode_e         mode,
    output logic               legal,
    output logic [DST_W-1:0]   dst
);

    logic [SIZE_W-1:0] size_f;
    logic              unused_fields;

    assign unused_fields = ^{instr[INSTR_W-1:POS_HALF+1],
                             instr[POS_HALF-1:POS_SIZE_LO+SIZE_W],
                             instr[POS_SIZE_LO-1:DST_W]};

    // Field extraction and legality of the size encoding
    always_comb begin
        size_f  = instr[POS_SIZE_LO +: SIZE_W];
        half_hi = instr[POS_HALF];
        dst     = instr[DST_W-1:0];
        case (size_f)
            SIZE_NARROW: begin
                legal = 1'b1;
                mode  = LANE_NARROW;
            end
            SIZE_WIDE: begin
                legal = wide_en;
                mode  = LANE_WIDE;
            end
            default: begin
                legal = 1'b0;
                mode  = LANE_NARROW;
            end
        endcase
    end

endmodule

// File: rtl/clmul_poly_mul.sv
// Module: clmul_poly_mul
// Combinational carry-less multiply of two W-bit polynomials over GF(2)
// into a 2W-bit product. Partial products are XOR-accumulated.
module clmul_poly_mul #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] acc;
    logic [PW-1:0] a_ext;

    assign a_ext = {{W{1'b0}}, a};

    // XOR-accumulate the shifted copies of a selected by the bits of b
    always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) begin
                acc = acc ^ (a_ext << i);
            end
        end
    end

    assign p = acc;

endmodule

// File: rtl/clmul_datapath.sv
// Module: clmul_datapath
// Holds the narrow-lane array and the single wide lane, and selects
// one of them by lane mode. Assumes HALF_W is a multiple of NARROW_W.
module clmul_datapath
    import clmul_pkg::*;
#(
    parameter int unsigned HALF_W   = 64,
    parameter int unsigned NARROW_W = 8
) (
    input  logic [HALF_W-1:0]   opa,
    input  logic [HALF_W-1:0]   opb,
    input  lane_mode_e          mode,
    output logic [2*HALF_W-1:0] prod
);

    localparam int unsigned NUM_LANES = HALF_W / NARROW_W;
    localparam int unsigned LANE_PW   = 2 * NARROW_W;

    logic [2*HALF_W-1:0] narrow_vec;
    logic [2*HALF_W-1:0] wide_vec;

    // One narrow multiplier per lane; lane products are packed in lane order
    for (genvar e = 0; e < NUM_LANES; e++) begin : g_lane
        clmul_poly_mul #(.W(NARROW_W)) u_lane (
            .a (opa[e*NARROW_W +: NARROW_W]),
            .b (opb[e*NARROW_W +: NARROW_W]),
            .p (narrow_vec[e*LANE_PW +: LANE_PW])
        );
    end

    clmul_poly_mul #(.W(HALF_W)) u_wide (
        .a (opa),
        .b (opb),
        .p (wide_vec)
    );

    // Pick the product vector of the active lane layout
    always_comb begin
        prod = (mode == LANE_WIDE) ? wide_vec : narrow_vec;
    end

endmodule

// File: rtl/clmul_long_unit.sv
// Module: clmul_long_unit (top)
// Two-stage carry-less multiply-long unit. Stage 1 registers the selected
// operand halves, the lane mode, the destination index and the legality.
// Stage 2 registers the product. Illegal encodings come out as out_undef
// with out_valid low. Assumes REG_W is even, with the half a multiple
// of NARROW_W.
module clmul_long_unit
    import clmul_pkg::*;
#(
    parameter int unsigned REG_W    = 128,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned INSTR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_en,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [REG_W-1:0]   src_a,
    input  logic [REG_W-1:0]   src_b,
    output logic               out_valid,
    output logic               out_undef,
    output logic [DST_W-1:0]   out_dst,
    output logic [REG_W-1:0]   out_result
);

    localparam int unsigned HALF_W = REG_W / 2;

    logic             dec_half_hi;
    lane_mode_e       dec_mode;
    logic             dec_legal;
    logic [DST_W-1:0] dec_dst;

    logic [HALF_W-1:0] sel_a;
    logic [HALF_W-1:0] sel_b;

    logic              s1_valid;
    logic              s1_undef;
    lane_mode_e        s1_mode;
    logic [DST_W-1:0]  s1_dst;
    logic [HALF_W-1:0] s1_a;
    logic [HALF_W-1:0] s1_b;

    logic [REG_W-1:0]  prod;

    clmul_decode #(.INSTR_W(INSTR_W)) u_decode (
        .instr   (in_instr),
        .wide_en (wide_en),
        .half_hi (dec_half_hi),
        .mode    (dec_mode),
        .legal   (dec_legal),
        .dst     (dec_dst)
    );

    // Operand half selection for both sources
    always_comb begin
        sel_a = dec_half_hi ? src_a[REG_W-1:HALF_W] : src_a[HALF_W-1:0];
        sel_b = dec_half_hi ? src_b[REG_W-1:HALF_W] : src_b[HALF_W-1:0];
    end

    // Stage 1 control: split the accepted instruction into legal and undefined
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_undef <= 1'b0;
            s1_dst   <= '0;
            s1_mode  <= LANE_NARROW;
        end else begin
            s1_valid <= in_valid && dec_legal;
            s1_undef <= in_valid && !dec_legal;
            if (in_valid) begin
                s1_dst  <= dec_dst;
                s1_mode <= dec_mode;
            end
        end
    end

    // Stage 1 data: capture operands only for legal instructions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_a <= '0;
            s1_b <= '0;
        end else if (in_valid && dec_legal) begin
            s1_a <= sel_a;
            s1_b <= sel_b;
        end
    end

    clmul_datapath #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_datapath (
        .opa  (s1_a),
        .opb  (s1_b),
        .mode (s1_mode),
        .prod (prod)
    );

    // Stage 2 control: strobes and destination index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
            out_dst   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_undef <= s1_undef;
            if (s1_valid || s1_undef) begin
                out_dst <= s1_dst;
            end
        end
    end

    // Stage 2 data: register the product of a legal instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
        end else if (s1_valid) begin
            out_result <= prod;
        end
    end

endmodule

// File: rtl/clmul_long_unit_chk.sv
// Module: clmul_long_unit_chk
// Protocol and shape checks for clmul_long_unit, attached by bind.
module clmul_long_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         wide_en,
    input logic         in_valid,
    input logic [31:0]  in_instr,
    input logic         out_valid,
    input logic         out_undef,
    input logic [4:0]   out_dst,
    input logic [127:0] out_result
);

    logic in_legal;
    assign in_legal = (in_instr[23:22] == 2'b00) ||
                      ((in_instr[23:22] == 2'b11) && wide_en);

    // R7: a legal issue gives out_valid exactly two cycles later
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_legal) |=> ##1 (out_valid && !out_undef));

    // R7: an idle cycle yields an idle result slot
    a_r7_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 (!out_valid && !out_undef));

    // R6: an illegal issue gives out_undef without out_valid
    a_r6_undef_path: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_legal) |=> ##1 (out_undef && !out_valid));

    // R6: the two strobes are never high together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_undef));

    // R8: the destination travels with its instruction
    a_r8_dst: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 (out_dst == $past(in_instr[4:0], 2)));

    // R4: the top bit of every 16-bit narrow lane product is zero
    a_r4_lane_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[23:22] == 2'b00) |=> ##1
        ((out_result & {8{16'h8000}}) == 128'd0));

    // R5: a wide product never reaches bit 127
    a_r5_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_result[127]);

    // R9: reset clears both strobes on the next edge
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_undef));

endmodule

bind clmul_long_unit clmul_long_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_en    (wide_en),
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_dst    (out_dst),
    .out_result (out_result)
);

// File: tb/clmul_long_unit_tb.sv
// Bench: sweeps every 8-bit operand pair through the narrow lanes, runs
// 64-bit corner and random cases, and interleaves illegal encodings.
// The expected values are computed from the GF(2) product definition.
module clmul_long_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wide_en = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_instr = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic         out_undef;
    logic [4:0]   out_dst;
    logic [127:0] out_result;

    int checks = 0;
    int fails  = 0;

    // expected pipeline: d1 = issued one edge ago, d2 = due now
    logic         e1v = 0, e1u = 0, e2v = 0, e2u = 0;
    logic [4:0]   e1d = 0, e2d = 0;
    logic [127:0] e1r = 0, e2r = 0;
    string        e1t = "R7", e2t = "R7";

    always #5 clk = ~clk;

    clmul_long_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_en    (wide_en),
        .in_valid   (in_valid),
        .in_instr   (in_instr),
        .src_a      (src_a),
        .src_b      (src_b),
        .out_valid  (out_valid),
        .out_undef  (out_undef),
        .out_dst    (out_dst),
        .out_result (out_result)
    );

    function automatic logic [127:0] ref_prod(input logic [63:0] x,
                                              input logic [63:0] y,
                                              input int lw);
        logic [127:0] r = '0;
        for (int l = 0; l < 64 / lw; l++)
            for (int i = 0; i < lw; i++)
                for (int j = 0; j < lw; j++)
                    if (x[l*lw+i] && y[l*lw+j])
                        r[l*2*lw+i+j] = r[l*2*lw+i+j] ^ 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic q, input logic [1:0] sz,
                                       input logic [4:0] rd);
        logic [4:0] rm = 5'($urandom);
        logic [4:0] rn = 5'($urandom);
        return {1'b0, q, 1'b0, 5'b01110, sz, 1'b1, rm, 6'b111000, rn, rd};
    endfunction

    task automatic step(input logic v, input logic [31:0] ins,
                        input logic [127:0] a, input logic [127:0] b,
                        input logic en, input string tag);
        logic [1:0]  sz;
        logic        lg;
        logic [63:0] x, y;
        @(negedge clk);
        checks++;
        if (out_valid !== e2v || out_undef !== e2u ||
            ((e2v || e2u) && out_dst !== e2d) ||
            (e2v && out_result !== e2r)) begin
            fails++;
            $display("FAIL %s: valid=%b undef=%b dst=%0d res=%h expected valid=%b undef=%b dst=%0d res=%h",
                     e2t, out_valid, out_undef, out_dst, out_result,
                     e2v, e2u, e2d, e2r);
        end
        e2v = e1v; e2u = e1u; e2d = e1d; e2r = e1r; e2t = e1t;
        sz = ins[23:22];
        lg = (sz == 2'b00) || (sz == 2'b11 && en);
        x  = ins[30] ? a[127:64] : a[63:0];
        y  = ins[30] ? b[127:64] : b[63:0];
        e1v = v && lg;
        e1u = v && !lg;
        e1d = ins[4:0];
        e1r = (sz == 2'b11) ? ref_prod(x, y, 64) : ref_prod(x, y, 8);
        e1t = tag;
        in_valid = v; in_instr = ins; src_a = a; src_b = b; wide_en = en;
    endtask

    function automatic logic [127:0] place(input logic q, input logic [63:0] h);
        logic [63:0] junk = {$urandom, $urandom};
        return q ? {h, junk} : {junk, h};
    endfunction

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R7: watchdog expired, actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9: in_valid during reset must produce nothing
        in_valid = 1'b1; in_instr = mk(1'b0, 2'b00, 5'd3); wide_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_undef !== 1'b0) begin
                fails++;
                $display("FAIL R9: valid=%b undef=%b expected 0 0", out_valid, out_undef);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R9: the first slots after reset are idle
        step(1'b0, '0, '0, '0, 1'b0, "R9");
        step(1'b0, '0, '0, '0, 1'b0, "R9");

        // R1 R4 R2 R3: all 8-bit operand pairs, alternating half-select
        for (int ai = 0; ai < 256; ai++) begin
            for (int g = 0; g < 32; g++) begin
                logic [63:0] ha, hb;
                logic        q = 1'((ai + g) % 2);
                for (int e = 0; e < 8; e++) begin
                    ha[e*8 +: 8] = 8'(ai);
                    hb[e*8 +: 8] = 8'(g * 8 + e);
                end
                step(1'b1, mk(q, 2'b00, 5'($urandom)), place(q, ha), place(q, hb),
                     1'($urandom), q ? "R3/R4" : "R2/R4");
            end
        end

        // R1 R5: 64-bit corners (all ones, zero, top bits set)
        step(1'b1, mk(1'b0, 2'b11, 5'd1), place(1'b0, '1), place(1'b0, '1), 1'b1, "R1");
        step(1'b1, mk(1'b1, 2'b11, 5'd2), place(1'b1, '1), place(1'b1, '1), 1'b1, "R1");
        step(1'b1, mk(1'b0, 2'b11, 5'd4), place(1'b0, '0), place(1'b0, 64'h1234_5678_9abc_def0), 1'b1, "R1");
        step(1'b1, mk(1'b1, 2'b11, 5'd5), place(1'b1, {1'b1, 62'd0, 1'b1}),
             place(1'b1, {1'b1, 63'd0}), 1'b1, "R5");
        step(1'b1, mk(1'b0, 2'b11, 5'd6), place(1'b0, {1'b1, 63'd0}),
             place(1'b0, {1'b1, 63'd0}), 1'b1, "R5");

        // R2 R3 R5: random wide products from both halves
        for (int k = 0; k < 40; k++) begin
            logic q = 1'(k % 2);
            step(1'b1, mk(q, 2'b11, 5'($urandom)),
                 place(q, {$urandom, $urandom}), place(q, {$urandom, $urandom}),
                 1'b1, q ? "R3/R5" : "R2/R5");
        end

        // R6 R7 R8: illegal and legal encodings back to back, enable toggling
        for (int k = 0; k < 64; k++) begin
            logic [1:0] sz = 2'(k % 4);
            logic       en = 1'((k / 4) % 2);
            logic       q  = 1'(k % 3 == 0);
            step(1'b1, mk(q, sz, 5'(k)), {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, en, "R6/R8");
        end

        // R7: idle cycles with junk instruction bits between issues
        for (int k = 0; k < 20; k++) begin
            step(1'(k % 3 == 0), mk(1'(k % 2), 2'b00, 5'(31 - k)),
                 {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, 1'b0, "R7");
        end

        // flush the pipeline
        step(1'b0, '0, '0, '0, 1'b0, "R7");
        step(1'b0, '0, '0, '0, 1'b0, "R7");
        step(1'b0, '0, '0, '0, 1'b0, "R7");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule